// File: doc/BRIEF.md
# Streaming Memory Read Responder

This block sits between a byte-level host link and a 2048-byte synchronous data store. It serves one kind of transaction. The host sends a read opcode and a two-byte start address. The block then hands back one stored byte per host request, walking upward through memory to the top location. It next returns a 16-bit check value over every byte the transaction carried, and after that it returns only all-ones bytes. A bus-reset pulse ends the transaction at any point and returns the block to waiting for an opcode.

Inbound bytes use a valid/ready handshake. Outbound bytes are pulled: the host raises `out_req` for one cycle, and the byte appears with `out_valid` on the next cycle. A data byte comes straight from the store's registered read port, which is why the latency is one cycle. The upper address bits beyond the store size are dropped. Any opcode other than the read opcode leaves the block returning all-ones until the next bus reset.

Top module: `rsr_stream_read`

## Requirements
- R1: After `rst_n` or `bus_rst`, `in_ready` is 1 and `out_valid` is 0. `in_ready` stays 1 only while the block waits for the opcode or an address byte, and is 0 from the cycle after the second address byte is accepted.
- R2: The read opcode is F0h. The first address byte after it supplies address bits 7:0 and the second supplies bits 15:8. Address bits 15:11 are ignored, so the start address is the 16-bit value modulo 2048.
- R3: An accepted `out_req` (one seen while `out_valid` is 0 and `bus_rst` is 0) makes `out_valid` high for exactly the next cycle. A request seen while `out_valid` is 1 is ignored.
- R4: During the data phase each accepted request drives `mem_en` with `mem_addr` in the same cycle. The returned bytes are the stored bytes from the start address upward through address 7FFh, one per request, with no gaps.
- R5: The two requests after the byte at 7FFh return a CRC-16: low byte first, then high byte. It uses the reflected polynomial A001h (x^16+x^15+x^2+1), starts at zero and consumes each byte LSB first. It covers the opcode, the two address bytes and every data byte returned, in that order.
- R6: Every request after the CRC high byte returns FFh until `bus_rst`.
- R7: `bus_rst` aborts any transaction: no CRC is produced, and the next opcode starts a new transaction whose CRC begins again from zero.
- R8: An opcode other than F0h makes every later request return FFh. `in_ready` stays 0 and `mem_en` stays 0 until `bus_rst`.
- R9: A request made before both address bytes are accepted returns FFh and does not assert `mem_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Synchronous transaction abort (bus reset pulse) |
| in_data | input | 8 | Inbound byte (opcode or address) |
| in_valid | input | 1 | Inbound byte present |
| in_ready | output | 1 | Block accepts an inbound byte |
| out_req | input | 1 | Host asks for the next outbound byte |
| out_valid | output | 1 | Outbound byte present, one cycle after request |
| out_data | output | 8 | Outbound byte |
| mem_en | output | 1 | Store read strobe |
| mem_addr | output | ADDR_W | Store read address |
| mem_rdata | input | 8 | Store read data, valid the cycle after `mem_en` |

## Verification
Each outbound byte is due exactly one cycle after its accepted request. The bench raises `out_req` on a falling edge and samples `out_valid` and `out_data` on the next falling edge, so one rising edge lies between the two. `mem_en` is checked combinationally, one nanosecond after the request is driven. Changes to `in_ready` take effect at the edge that accepts a byte, so the bench reads `in_ready` on the falling edge after each send. The CRC is due two requests after the request for address 7FFh, and the bench compares it with a value it computes from the bytes it has exchanged.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
   localparam int BYTE_W = 8;
   localparam int CRC_W  = 16;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_TA1,
      ST_TA2,
      ST_DATA,
      ST_CRCL,
      ST_CRCH,
      ST_ONES
   } rsr_state_e;
endpackage

// File: rtl/rsr_crc16.sv
// Byte-wide reflected CRC accumulator: eight LSB-first bit steps unrolled.
module rsr_crc16
   import rsr_pkg::*;
#(
   parameter logic [CRC_W-1:0] POLY = 16'hA001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [BYTE_W-1:0] din,
   output logic [CRC_W-1:0]  crc
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] stage [0:BYTE_W];

   assign stage[0] = clr ? '0 : crc_q;

   for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      logic fb;
      assign fb           = stage[i][0] ^ din[i];
      assign stage[i + 1] = (stage[i] >> 1) ^ (fb ? POLY : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= '0;
      else if (en)  crc_q <= stage[BYTE_W];
      else if (clr) crc_q <= '0;
   end

   assign crc = crc_q;
endmodule

// File: rtl/rsr_addr_gen.sv
// Start address capture (upper bits dropped) and post-increment pointer.
module rsr_addr_gen
   import rsr_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic              inc,
   input  logic [BYTE_W-1:0] din,
   output logic [ADDR_W-1:0] addr,
   output logic              at_last
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
   localparam int HI_W = ADDR_W - BYTE_W;

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (ld_lo) begin
         addr_q[BYTE_W-1:0] <= din;
      end else if (ld_hi) begin
         addr_q[ADDR_W-1:BYTE_W] <= din[HI_W-1:0];
      end else if (inc) begin
         addr_q <= addr_q + 1'b1;
      end
   end

   assign addr    = addr_q;
   assign at_last = (addr_q == LAST_ADDR);
endmodule

// File: rtl/rsr_stream_read.sv
module rsr_stream_read
   import rsr_pkg::*;
#(
   parameter int               ADDR_W   = 11,
   parameter logic [7:0]       READ_CMD = 8'hF0,
   parameter logic [CRC_W-1:0] CRC_POLY = 16'hA001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rst,
   input  logic [7:0]        in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              out_req,
   output logic              out_valid,
   output logic [7:0]        out_data,
   output logic              mem_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata
);
   localparam logic [BYTE_W-1:0] ONES = '1;

   if (ADDR_W <= BYTE_W || ADDR_W > 2 * BYTE_W) begin : g_bad_aw
      $error("ADDR_W must lie in 9..16");
   end
   if (BYTE_W != 8) begin : g_bad_bw
      $error("byte width must be 8");
   end

   rsr_state_e        state_q, state_d;
   logic              pend_q, pend_mem_q;
   logic [BYTE_W-1:0] hold_q;
   logic              take_in, take_req, at_last;
   logic              crc_clr, crc_en;
   logic [BYTE_W-1:0] crc_din;
   logic [CRC_W-1:0]  crc;

   assign in_ready = (state_q == ST_CMD) || (state_q == ST_TA1) || (state_q == ST_TA2);
   assign take_in  = in_ready && in_valid && !bus_rst;
   assign take_req = out_req && !pend_q && !bus_rst;
   assign mem_en   = take_req && (state_q == ST_DATA);

   always_comb begin
      state_d = state_q;
      if (bus_rst) begin
         state_d = ST_CMD;
      end else begin
         unique case (state_q)
            ST_CMD:  if (take_in) state_d = (in_data == READ_CMD) ? ST_TA1 : ST_ONES;
            ST_TA1:  if (take_in) state_d = ST_TA2;
            ST_TA2:  if (take_in) state_d = ST_DATA;
            ST_DATA: if (take_req && at_last) state_d = ST_CRCL;
            ST_CRCL: if (take_req) state_d = ST_CRCH;
            ST_CRCH: if (take_req) state_d = ST_ONES;
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_CMD;
         pend_q     <= 1'b0;
         pend_mem_q <= 1'b0;
         hold_q     <= ONES;
      end else begin
         state_q    <= state_d;
         pend_q     <= take_req;
         pend_mem_q <= mem_en;
         if (take_req) begin
            unique case (state_q)
               ST_CRCL: hold_q <= crc[BYTE_W-1:0];
               ST_CRCH: hold_q <= crc[CRC_W-1:BYTE_W];
               default: hold_q <= ONES;
            endcase
         end
      end
   end

   // CRC intake: opcode clears and seeds, address bytes follow, then each data byte as it returns
   assign crc_clr = take_in && (state_q == ST_CMD);
   assign crc_en  = take_in || (pend_q && pend_mem_q && !bus_rst);
   assign crc_din = pend_mem_q ? mem_rdata : in_data;

   rsr_crc16 #(.POLY(CRC_POLY)) u_crc (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (crc_clr),
      .en   (crc_en),
      .din  (crc_din),
      .crc  (crc)
   );

   rsr_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_lo  (take_in && (state_q == ST_TA1)),
      .ld_hi  (take_in && (state_q == ST_TA2)),
      .inc    (mem_en),
      .din    (in_data),
      .addr   (mem_addr),
      .at_last(at_last)
   );

   assign out_valid = pend_q;
   assign out_data  = pend_mem_q ? mem_rdata : hold_q;
endmodule

// File: rtl/rsr_stream_read_chk.sv
module rsr_stream_read_chk #(
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rst,
   input logic              in_ready,
   input logic              out_req,
   input logic              out_valid,
   input logic              mem_en,
   input logic [ADDR_W-1:0] mem_addr
);
   logic              seen_q;
   logic [ADDR_W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         prev_q <= '0;
      end else if (bus_rst) begin
         seen_q <= 1'b0;
      end else if (mem_en) begin
         seen_q <= 1'b1;
         prev_q <= mem_addr;
      end
   end

   // R3
   req_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_req && !out_valid && !bus_rst) |=> out_valid);

   // R3
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R4
   mem_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !bus_rst) |=> out_valid);

   // R4
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && seen_q) |-> (mem_addr == ADDR_W'(prev_q + 1'b1)));

   // R1
   ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> !in_ready);

   // R7
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> (in_ready && !out_valid));
endmodule

bind rsr_stream_read rsr_stream_read_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_rst  (bus_rst),
   .in_ready (in_ready),
   .out_req  (out_req),
   .out_valid(out_valid),
   .mem_en   (mem_en),
   .mem_addr (mem_addr)
);

// File: tb/tb_rsr_stream_read.sv
`timescale 1ns/1ps
module tb_rsr_stream_read;
   localparam int AW = 11;
   localparam int LAST = (1 << AW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_rst = 1'b0;
   logic [7:0]    in_data = '0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic          out_req = 1'b0;
   logic          out_valid;
   logic [7:0]    out_data;
   logic          mem_en;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_q;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   rsr_stream_read dut (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .out_req(out_req), .out_valid(out_valid), .out_data(out_data),
      .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_q)
   );

   function automatic logic [7:0] mval(int a);
      return 8'((a * 37) ^ (a >> 4) ^ 8'h5A);
   endfunction

   always_ff @(posedge clk) if (mem_en) mem_q <= mval(int'(mem_addr));

   function automatic logic [15:0] crc_upd(logic [15:0] c, logic [7:0] b);
      logic [15:0] r = c;
      for (int i = 0; i < 8; i++) begin
         logic fb = r[0] ^ b[i];
         r = r >> 1;
         if (fb) r = r ^ 16'hA001;
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      in_data  = b;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic get(output logic [7:0] b, output logic vld, output logic men);
      @(negedge clk);
      out_req = 1'b1;
      #1 men = mem_en;
      @(negedge clk);
      out_req = 1'b0;
      vld = out_valid;
      b   = out_data;
   endtask

   task automatic pulse_bus_rst();
      @(negedge clk);
      bus_rst = 1'b1;
      @(negedge clk);
      bus_rst = 1'b0;
      chk(in_ready === 1'b1 && out_valid === 1'b0, "R7", {in_ready, out_valid}, 2'b10);
   endtask

   // Full read from a 16-bit start value through end, CRC and trailing ones
   task automatic full_read(input logic [15:0] start, input string rq);
      logic [15:0] c;
      logic [7:0]  b;
      logic        v, me;
      int          a;
      c = crc_upd(16'h0, 8'hF0);
      send(8'hF0);
      send(start[7:0]);  c = crc_upd(c, start[7:0]);
      send(start[15:8]); c = crc_upd(c, start[15:8]);
      chk(in_ready === 1'b0, "R1", in_ready, 0);
      for (a = int'(start) % (LAST + 1); a <= LAST; a++) begin
         get(b, v, me);
         chk(v === 1'b1 && me === 1'b1 && b === mval(a), rq, b, mval(a));
         c = crc_upd(c, mval(a));
      end
      get(b, v, me);
      chk(v === 1'b1 && me === 1'b0 && b === c[7:0], "R5", b, c[7:0]);
      get(b, v, me);
      chk(v === 1'b1 && b === c[15:8], "R5", b, c[15:8]);
      for (int k = 0; k < 3; k++) begin
         get(b, v, me);
         chk(v === 1'b1 && me === 1'b0 && b === 8'hFF, "R6", b, 8'hFF);
      end
      pulse_bus_rst();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] b;
      logic       v, me;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(in_ready === 1'b1 && out_valid === 1'b0, "R1", {in_ready, out_valid}, 2'b10);

      full_read(16'h07F0, "R4");
      full_read(16'h07FF, "R4");
      full_read(16'hFFF5, "R2");   // upper five bits dropped -> 7F5h
      full_read(16'h0000, "R4");
      full_read(16'h0400, "R4");

      // R7: abort mid-read, then a fresh transaction
      send(8'hF0); send(8'h10); send(8'h00);
      for (int k = 0; k < 5; k++) begin
         get(b, v, me);
         chk(v === 1'b1 && b === mval(16 + k), "R4", b, mval(16 + k));
      end
      pulse_bus_rst();
      get(b, v, me);
      chk(b === 8'hFF && me === 1'b0, "R7", {me, b}, 9'h0FF);
      full_read(16'h07FC, "R7");

      // R8: unknown opcode
      send(8'h0F);
      chk(in_ready === 1'b0, "R8", in_ready, 0);
      send(8'h00);
      for (int k = 0; k < 4; k++) begin
         get(b, v, me);
         chk(v === 1'b1 && me === 1'b0 && b === 8'hFF, "R8", {me, b}, 9'h0FF);
      end
      pulse_bus_rst();

      // R9: request before address complete
      send(8'hF0); send(8'hFE);
      get(b, v, me);
      chk(v === 1'b1 && me === 1'b0 && b === 8'hFF, "R9", {me, b}, 9'h0FF);
      send(8'h07);
      // R3: request held high across the valid cycle is taken only once
      @(negedge clk);
      out_req = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b1 && out_data === mval(12'h7FE), "R3", out_data, mval(12'h7FE));
      @(negedge clk);
      out_req = 1'b0;
      chk(out_valid === 1'b0, "R3", out_valid, 0);
      get(b, v, me);
      chk(v === 1'b1 && b === mval(LAST), "R3", b, mval(LAST));
      pulse_bus_rst();

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule